// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the software-facing register port of a single eight-line interrupt controller. A processor talks to it through a one-bit address, a write strobe, a read strobe and byte-wide data. Writes drive a multi-word start-up sequence. That sequence sets the vector base, the nesting mode and automatic end-of-interrupt. Later writes load the line mask and issue operation commands: end-of-interrupt variants, priority rotation, read selection, poll and special mask. Reads return the mask, the in-service set, the pending set, or a poll result.

A neighbouring request latch supplies the pending vector. It drops the bits this block names on its clear output. The block ranks candidates by rotating priority around a programmable base. It raises the interrupt output when a candidate outranks everything in service. When the acknowledge strobe arrives, it answers with the vector base plus the winning line, or with a spurious vector.

Top module: `pic_cmd_if`

## Requirements
- R1: A write at address 0 with data bit 4 set starts initialization. It clears the mask, in-service set, rotation base, vector base, read select, poll flag and all mode flags. It drives `pend_clr_o` to all ones in that cycle, and holds `irq_o` low until the sequence finishes. Data bit 0 is kept as "mode word follows".
- R2: During initialization, address-1 writes are taken in order. The first sets the vector base to data AND 0xF8. The second is discarded. The sequence then ends, or it waits for a mode word if R1's flag was set. In the mode word, bit 4 sets `nest_o` and bit 1 enables automatic end-of-interrupt.
- R3: Outside initialization, an address-1 write loads the mask. An address-1 read returns the mask. Masked pending lines never win.
- R4: An address-0 write with bit 4 clear and bit 3 set is a read command. Bit 2 sets poll. If bit 1 is set, bit 0 selects what an address-0 read returns: in-service (1) or pending (0). If bit 6 is set, bit 5 sets `smask_o`.
- R5: A line's rank is (line − rotation base) mod 8, and 0 is the best rank. The winner is the best-ranked line in pending AND NOT mask, provided its rank beats the best-ranked in-service line. `irq_o` is high when a winner exists and initialization is idle.
- R6: An address-0 write with bits 4:3 zero carries an opcode in bits 7:5. Opcode 1 clears the best-ranked in-service bit. Opcode 5 also sets the rotation base to that line + 1. Both leave all state unchanged if nothing is in service.
- R7: Opcode 3 clears the in-service bit named by data bits 2:0. Opcode 7 also sets the rotation base to that line + 1. Opcode 6 sets the rotation base to data bits 2:0 + 1 mod 8. Opcode 2 does nothing. Opcodes 0 and 4 clear and set rotate-on-auto-end.
- R8: While poll is set, an address-0 or address-1 read returns the winner's line number (bits 7:3 zero), or 7 if there is none. At the read strobe the winner's pending bit is cleared and poll drops.
- R9: On acknowledge with a winner, `vec_o` is vector base + line. The line's pending bit is pulsed on `pend_clr_o` and its in-service bit is set. With automatic end-of-interrupt, the in-service bit is not set. If rotate-on-auto-end is also on, the rotation base becomes line + 1.
- R10: On acknowledge with no winner, `vec_o` is vector base + 7 and no state changes.
- R11: Acknowledge and an end-of-interrupt write may share a cycle. The result is (in-service OR acknowledged bit) AND NOT the cleared bit. A non-specific clear picks from the in-service set as it stood before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 1 | Register address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, commits poll side effects |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pend_i | input | 8 | Pending lines from the request latch |
| pend_clr_o | output | 8 | Per-line clear pulse to the request latch |
| ack_i | input | 1 | Acknowledge strobe |
| vec_o | output | 8 | Vector returned for the acknowledge |
| irq_o | output | 1 | Interrupt request to the processor |
| nest_o | output | 1 | Special nesting mode flag |
| smask_o | output | 1 | Special mask mode flag |

## Verification
An acknowledge and an end-of-interrupt write can land in the same clock. Both edit the in-service set, and the non-specific form reads it. The bench drives both strobes together in two cases. The first pairs a specific clear of one line with the acknowledge of another. The second pairs a non-specific clear with the acknowledge of a line that outranks the one already in service. The in-service set is then read back and must show the old top bit cleared and the new line set; taking the choice from the updated set would clear the new line instead.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  localparam int NLINE = 8;
  localparam int LW    = $clog2(NLINE);
  localparam int RW    = LW + 1;
  localparam int DW    = 8;

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_SKIP, ST_MODE} init_st_e;

  typedef enum logic [2:0] {
    OP_ROT_OFF  = 3'd0,
    OP_EOI      = 3'd1,
    OP_NOP      = 3'd2,
    OP_EOI_AT   = 3'd3,
    OP_ROT_ON   = 3'd4,
    OP_EOI_ROT  = 3'd5,
    OP_SET_BASE = 3'd6,
    OP_AT_ROT   = 3'd7
  } op_e;

  typedef struct packed {
    logic init;
    logic word;
    logic rdcmd;
    logic op_vld;
    op_e  op;
  } cmd_t;

  // lowest set index of a vector, NLINE when empty
  function automatic logic [RW-1:0] first_set(input logic [NLINE-1:0] v);
    logic [RW-1:0] r;
    r = RW'(NLINE);
    for (int i = NLINE - 1; i >= 0; i--)
      if (v[i]) r = RW'(i);
    return r;
  endfunction

  function automatic logic [NLINE-1:0] line_bit(input logic [LW-1:0] l);
    return NLINE'(1) << l;
  endfunction

  function automatic logic [LW-1:0] next_line(input logic [LW-1:0] l);
    return l + LW'(1);
  endfunction
endpackage

// File: rtl/pic_prio_pick.sv
module pic_prio_pick
  import pic_cmd_pkg::*;
(
  input  logic [NLINE-1:0] req_i,
  input  logic [NLINE-1:0] isr_i,
  input  logic [LW-1:0]    base_i,
  output logic             win_vld_o,
  output logic [LW-1:0]    win_line_o,
  output logic             top_vld_o,
  output logic [LW-1:0]    top_line_o
);
  logic [NLINE-1:0] req_rot;
  logic [NLINE-1:0] isr_rot;
  logic [RW-1:0]    req_rk;
  logic [RW-1:0]    isr_rk;

  // rank r holds line (r + base) mod NLINE
  for (genvar r = 0; r < NLINE; r++) begin : g_rot
    localparam logic [LW-1:0] RK = LW'(r);
    assign req_rot[r] = req_i[RK + base_i];
    assign isr_rot[r] = isr_i[RK + base_i];
  end

  assign req_rk     = first_set(req_rot);
  assign isr_rk     = first_set(isr_rot);
  assign win_vld_o  = req_rk < isr_rk;
  assign win_line_o = req_rk[LW-1:0] + base_i;
  assign top_vld_o  = !isr_rk[LW];
  assign top_line_o = isr_rk[LW-1:0] + base_i;
endmodule

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
  import pic_cmd_pkg::*;
(
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output cmd_t          cmd_o
);
  always_comb begin
    cmd_o        = '0;
    cmd_o.op     = op_e'(wdata_i[7:5]);
    if (wr_i) begin
      if (addr_i) begin
        cmd_o.word = 1'b1;
      end else if (wdata_i[4]) begin
        cmd_o.init = 1'b1;
      end else if (wdata_i[3]) begin
        cmd_o.rdcmd = 1'b1;
      end else begin
        cmd_o.op_vld = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs
  import pic_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_t             cmd_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ack_hit_i,
  input  logic             poll_rd_i,
  input  logic             poll_hit_i,
  input  logic [LW-1:0]    win_line_i,
  input  logic             top_vld_i,
  input  logic [LW-1:0]    top_line_i,
  output init_st_e         st_o,
  output logic [NLINE-1:0] imr_o,
  output logic [NLINE-1:0] isr_o,
  output logic [LW-1:0]    base_o,
  output logic [DW-1:0]    vbase_o,
  output logic             rsel_o,
  output logic             poll_o,
  output logic             smask_o,
  output logic             nest_o,
  output logic             aeoi_o,
  output logic             rot_o,
  output logic [NLINE-1:0] isr_set_o,
  output logic [NLINE-1:0] isr_clr_o
);
  localparam logic [DW-1:0] VB_MASK = ~DW'(NLINE - 1);

  logic          ic4_q;
  logic [LW-1:0] base_nxt;
  logic [LW-1:0] at_line;

  assign at_line = wdata_i[LW-1:0];

  always_comb begin
    isr_set_o = (ack_hit_i && !aeoi_o) ? line_bit(win_line_i) : '0;
    isr_clr_o = poll_hit_i ? line_bit(win_line_i) : '0;
    base_nxt  = base_o;
    if (ack_hit_i && aeoi_o && rot_o)
      base_nxt = next_line(win_line_i);
    if (cmd_i.op_vld) begin
      unique case (cmd_i.op)
        OP_EOI: if (top_vld_i) isr_clr_o = isr_clr_o | line_bit(top_line_i);
        OP_EOI_ROT: if (top_vld_i) begin
          isr_clr_o = isr_clr_o | line_bit(top_line_i);
          base_nxt  = next_line(top_line_i);
        end
        OP_EOI_AT: isr_clr_o = isr_clr_o | line_bit(at_line);
        OP_AT_ROT: begin
          isr_clr_o = isr_clr_o | line_bit(at_line);
          base_nxt  = next_line(at_line);
        end
        OP_SET_BASE: base_nxt = next_line(at_line);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_o    <= ST_RUN;
      ic4_q   <= 1'b0;
      imr_o   <= '0;
      isr_o   <= '0;
      base_o  <= '0;
      vbase_o <= '0;
      rsel_o  <= 1'b0;
      poll_o  <= 1'b0;
      smask_o <= 1'b0;
      nest_o  <= 1'b0;
      aeoi_o  <= 1'b0;
      rot_o   <= 1'b0;
    end else if (cmd_i.init) begin
      st_o    <= ST_BASE;
      ic4_q   <= wdata_i[0];
      imr_o   <= '0;
      isr_o   <= '0;
      base_o  <= '0;
      vbase_o <= '0;
      rsel_o  <= 1'b0;
      poll_o  <= 1'b0;
      smask_o <= 1'b0;
      nest_o  <= 1'b0;
      aeoi_o  <= 1'b0;
      rot_o   <= 1'b0;
    end else begin
      isr_o  <= (isr_o | isr_set_o) & ~isr_clr_o;
      base_o <= base_nxt;
      if (cmd_i.word) begin
        unique case (st_o)
          ST_RUN:  imr_o <= wdata_i[NLINE-1:0];
          ST_BASE: begin
            vbase_o <= wdata_i & VB_MASK;
            st_o    <= ST_SKIP;
          end
          ST_SKIP: st_o <= ic4_q ? ST_MODE : ST_RUN;
          ST_MODE: begin
            nest_o <= wdata_i[4];
            aeoi_o <= wdata_i[1];
            st_o   <= ST_RUN;
          end
          default: st_o <= ST_RUN;
        endcase
      end
      if (poll_rd_i) poll_o <= 1'b0;
      if (cmd_i.rdcmd) begin
        if (wdata_i[2]) poll_o  <= 1'b1;
        if (wdata_i[1]) rsel_o  <= wdata_i[0];
        if (wdata_i[6]) smask_o <= wdata_i[5];
      end
      if (cmd_i.op_vld && cmd_i.op == OP_ROT_OFF) rot_o <= 1'b0;
      if (cmd_i.op_vld && cmd_i.op == OP_ROT_ON)  rot_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NLINE-1:0] pend_i,
  output logic [NLINE-1:0] pend_clr_o,
  input  logic             ack_i,
  output logic [DW-1:0]    vec_o,
  output logic             irq_o,
  output logic             nest_o,
  output logic             smask_o
);
  localparam logic [LW-1:0] SPUR_LINE = LW'(NLINE - 1);

  cmd_t             cmd;
  init_st_e         st;
  logic [NLINE-1:0] imr, isr, isr_set, isr_clr;
  logic [LW-1:0]    rb, win_line, top_line;
  logic [DW-1:0]    vbase;
  logic             rsel, poll, aeoi, rot;
  logic             win_vld, top_vld;
  // named events for the checker
  logic             ev_init, ack_hit, poll_rd, poll_hit;
  logic [LW-1:0]    resp_line;

  pic_cmd_decode u_dec (
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cmd_o   (cmd)
  );

  pic_prio_pick u_pick (
    .req_i      (pend_i & ~imr),
    .isr_i      (isr),
    .base_i     (rb),
    .win_vld_o  (win_vld),
    .win_line_o (win_line),
    .top_vld_o  (top_vld),
    .top_line_o (top_line)
  );

  assign ev_init  = cmd.init;
  assign ack_hit  = ack_i && win_vld;
  assign poll_rd  = rd_i && poll;
  assign poll_hit = poll_rd && win_vld;

  pic_cmd_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd),
    .wdata_i    (wdata_i),
    .ack_hit_i  (ack_hit),
    .poll_rd_i  (poll_rd),
    .poll_hit_i (poll_hit),
    .win_line_i (win_line),
    .top_vld_i  (top_vld),
    .top_line_i (top_line),
    .st_o       (st),
    .imr_o      (imr),
    .isr_o      (isr),
    .base_o     (rb),
    .vbase_o    (vbase),
    .rsel_o     (rsel),
    .poll_o     (poll),
    .smask_o    (smask_o),
    .nest_o     (nest_o),
    .aeoi_o     (aeoi),
    .rot_o      (rot),
    .isr_set_o  (isr_set),
    .isr_clr_o  (isr_clr)
  );

  assign resp_line = win_vld ? win_line : SPUR_LINE;
  assign vec_o     = vbase + DW'(resp_line);
  assign irq_o     = win_vld && (st == ST_RUN);

  always_comb begin
    pend_clr_o = '0;
    if (ev_init) pend_clr_o = '1;
    else begin
      if (ack_hit)  pend_clr_o = pend_clr_o | line_bit(win_line);
      if (poll_hit) pend_clr_o = pend_clr_o | line_bit(win_line);
    end
  end

  always_comb begin
    if (poll)        rdata_o = DW'(resp_line);
    else if (addr_i) rdata_o = DW'(imr);
    else if (rsel)   rdata_o = DW'(isr);
    else             rdata_o = DW'(pend_i);
  end
endmodule

// File: rtl/pic_cmd_if_chk.sv
module pic_cmd_if_chk
  import pic_cmd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             addr_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [DW-1:0]    wdata_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [DW-1:0]    vec_o,
  input logic [NLINE-1:0] pend_clr_o,
  input init_st_e         st,
  input logic [NLINE-1:0] imr,
  input logic [NLINE-1:0] isr,
  input logic [LW-1:0]    rb,
  input logic             poll,
  input logic             aeoi,
  input logic             win_vld,
  input logic [LW-1:0]    win_line,
  input logic             top_vld,
  input logic             ev_init,
  input logic             ack_hit
);
  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_init |=> (!irq_o && imr == '0 && isr == '0 && rb == '0)); // R1

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i && st == ST_RUN) |=> (imr == $past(wdata_i[NLINE-1:0]))); // R3

  AST_IRQ_NEEDS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (win_vld && st == ST_RUN)); // R5

  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_i && wdata_i[4:3] == 2'b00 && wdata_i[6:5] == 2'b01
     && !top_vld && !ack_hit) |=> (isr == '0 && $stable(rb))); // R6

  AST_POLL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && poll && !wr_i) |=> !poll); // R8

  AST_ACK_ONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !ev_init && !rd_i) |-> $onehot0(pend_clr_o)); // R9

  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !aeoi && !wr_i) |=> isr[$past(win_line)]); // R9

  AST_SPUR_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !win_vld) |-> (vec_o[LW-1:0] == '1 && pend_clr_o == '0)); // R10
endmodule

bind pic_cmd_if pic_cmd_if_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wdata_i    (wdata_i),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .vec_o      (vec_o),
  .pend_clr_o (pend_clr_o),
  .st         (st),
  .imr        (imr),
  .isr        (isr),
  .rb         (rb),
  .poll       (poll),
  .aeoi       (aeoi),
  .win_vld    (win_vld),
  .win_line   (win_line),
  .top_vld    (top_vld),
  .ev_init    (ev_init),
  .ack_hit    (ack_hit)
);

// File: tb/sim_pic_cmd_if.sv
module sim_pic_cmd_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pend = 8'h00;
  logic [7:0] rdata, pend_clr, vec;
  logic       irq, nest, smask;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] got, p, exp;

  always #5 clk = ~clk;

  pic_cmd_if u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .pend_i(pend), .pend_clr_o(pend_clr),
    .ack_i(ack), .vec_o(vec), .irq_o(irq), .nest_o(nest), .smask_o(smask)
  );

  task automatic chk(input string tag, input logic [7:0] g, input logic [7:0] e);
    n_chk++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, g, e);
    end
  endtask

  // one clock; models the request latch dropping the named lines
  task automatic tick();
    logic [7:0] c;
    #1 c = pend_clr;
    @(posedge clk);
    #1 pend = pend & ~c;
    @(negedge clk);
  endtask

  task automatic wr_op(input logic a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0;
  endtask

  task automatic rd_op(input logic a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    tick();
    rd = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic ack_op(output logic [7:0] v);
    ack = 1'b1;
    #1 v = vec;
    tick();
    ack = 1'b0;
  endtask

  task automatic ack_wr(input logic [7:0] d, output logic [7:0] v);
    addr = 1'b0; wdata = d; wr = 1'b1; ack = 1'b1;
    #1 v = vec;
    tick();
    wr = 1'b0; ack = 1'b0;
  endtask

  task automatic get_isr(output logic [7:0] v);
    wr_op(1'b0, 8'h0B);
    peek(1'b0, v);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 got=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    #1 chk("R5 irq after reset", {7'b0, irq}, 8'h00);
    chk("R9 no clear after reset", pend_clr, 8'h00);
    peek(1'b1, got); chk("R3 mask after reset", got, 8'h00);

    // R1: init pulse and quiet output
    addr = 1'b0; wdata = 8'h11; wr = 1'b1;
    #1 chk("R1 init clears pending", pend_clr, 8'hFF);
    tick(); wr = 1'b0;
    pend = 8'h01;
    #1 chk("R1 irq low in init", {7'b0, irq}, 8'h00);
    wr_op(1'b1, 8'h4D);
    #1 chk("R1 irq low after base word", {7'b0, irq}, 8'h00);
    wr_op(1'b1, 8'h00);
    wr_op(1'b1, 8'h00);
    #1 chk("R5 irq after sequence", {7'b0, irq}, 8'h01);
    chk("R2 nest off", {7'b0, nest}, 8'h00);
    ack_op(got); chk("R2 R9 vector base masked", got, 8'h48);
    chk("R9 pending cleared", pend, 8'h00);
    get_isr(got); chk("R9 in-service set", got, 8'h01);

    // R6: non-specific clear, then again on empty set
    wr_op(1'b0, 8'h20); get_isr(got); chk("R6 eoi clears", got, 8'h00);
    wr_op(1'b0, 8'h20); get_isr(got); chk("R6 eoi on empty", got, 8'h00);

    // R3: mask
    wr_op(1'b1, 8'hA5); peek(1'b1, got); chk("R3 mask readback", got, 8'hA5);
    pend = 8'h01;
    #1 chk("R3 masked line ignored", {7'b0, irq}, 8'h00);
    wr_op(1'b1, 8'h00);
    #1 chk("R3 unmasked line raises", {7'b0, irq}, 8'h01);
    pend = 8'h00;

    // R5 R8: sweep rotation base and pending patterns through poll
    for (int b = 0; b < 8; b++) begin
      wr_op(1'b0, 8'hC0 | 8'((b + 7) % 8));
      for (int k = 0; k < 6; k++) begin
        p = 8'(k * 53 + b * 29 + 1);
        if (p == 8'h00) p = 8'h01;
        pend = p;
        exp = 8'hFF;
        for (int j = 0; j < 8; j++)
          if (exp == 8'hFF && p[(b + j) % 8]) exp = 8'((b + j) % 8);
        wr_op(1'b0, 8'h0C);
        rd_op(1'b0, got);
        chk("R5 R8 poll winner", got, exp);
        chk("R8 poll clears pending", pend, p & ~(8'h01 << exp[2:0]));
      end
    end
    get_isr(got); chk("R8 poll leaves in-service", got, 8'h00);

    // R5 R6: nesting and rotating clear
    wr_op(1'b0, 8'hC7);
    pend = 8'h08; ack_op(got); chk("R9 vector line 3", got, 8'h4B);
    pend = 8'h20;
    #1 chk("R5 lower rank blocked", {7'b0, irq}, 8'h00);
    pend = 8'h22;
    #1 chk("R5 higher rank passes", {7'b0, irq}, 8'h01);
    ack_op(got); chk("R9 vector line 1", got, 8'h49);
    get_isr(got); chk("R9 nested in-service", got, 8'h0A);
    wr_op(1'b0, 8'h20); get_isr(got); chk("R6 eoi clears top", got, 8'h08);
    wr_op(1'b0, 8'hA0); get_isr(got); chk("R6 rotating eoi clears", got, 8'h00);
    pend = 8'h21; wr_op(1'b0, 8'h0C); rd_op(1'b0, got);
    chk("R6 rotation base to 4", got, 8'h05);

    // R7: specific clears, no-op, set base
    pend = 8'h41; ack_op(got); chk("R7 vector line 6", got, 8'h4E);
    wr_op(1'b0, 8'h66); get_isr(got); chk("R7 specific clear", got, 8'h00);
    ack_op(got); chk("R7 vector line 0", got, 8'h48);
    wr_op(1'b0, 8'h40); get_isr(got); chk("R7 opcode 2 no effect", got, 8'h01);
    wr_op(1'b0, 8'hE0); get_isr(got); chk("R7 specific rotating clear", got, 8'h00);
    pend = 8'h03; wr_op(1'b0, 8'h0C); rd_op(1'b0, got);
    chk("R7 rotation base to 1", got, 8'h01);

    // R11: acknowledge and clear in one cycle
    wr_op(1'b0, 8'hC7);
    pend = 8'h04; ack_op(got); chk("R11 setup vector", got, 8'h4A);
    pend = 8'h02; ack_wr(8'h62, got); chk("R11 vector with specific", got, 8'h49);
    get_isr(got); chk("R11 specific plus ack", got, 8'h02);
    pend = 8'h01; ack_wr(8'h20, got); chk("R11 vector with eoi", got, 8'h48);
    get_isr(got); chk("R11 eoi uses old set", got, 8'h01);

    // R10: spurious
    wr_op(1'b0, 8'h20);
    pend = 8'h00; ack_op(got); chk("R10 spurious vector", got, 8'h4F);
    get_isr(got); chk("R10 no in-service change", got, 8'h00);
    wr_op(1'b0, 8'h0C); rd_op(1'b0, got); chk("R8 poll empty gives 7", got, 8'h07);

    // R2 R9 R7: auto end with rotation
    wr_op(1'b0, 8'h11); wr_op(1'b1, 8'h20); wr_op(1'b1, 8'h00); wr_op(1'b1, 8'h12);
    #1 chk("R2 nest from mode word", {7'b0, nest}, 8'h01);
    wr_op(1'b0, 8'h80);
    pend = 8'h04; ack_op(got); chk("R9 auto vector", got, 8'h22);
    get_isr(got); chk("R9 auto end leaves nothing", got, 8'h00);
    pend = 8'h0C; wr_op(1'b0, 8'h0C); rd_op(1'b0, got);
    chk("R9 auto rotation to 3", got, 8'h03);
    wr_op(1'b0, 8'h00);
    pend = 8'h18; ack_op(got); chk("R7 vector after rotate off", got, 8'h23);
    pend = 8'h18; wr_op(1'b0, 8'h0C); rd_op(1'b0, got);
    chk("R7 rotate off keeps base", got, 8'h03);

    // R2 R4: short sequence, read select, special mask
    wr_op(1'b0, 8'h10); wr_op(1'b1, 8'h08); wr_op(1'b1, 8'h00);
    wr_op(1'b1, 8'h55); peek(1'b1, got); chk("R2 short sequence ends", got, 8'h55);
    pend = 8'h33; ack_op(got); chk("R3 mask steers vector", got, 8'h09);
    wr_op(1'b0, 8'h68);
    #1 chk("R4 special mask on", {7'b0, smask}, 8'h01);
    wr_op(1'b0, 8'h48);
    #1 chk("R4 special mask off", {7'b0, smask}, 8'h00);
    wr_op(1'b0, 8'h0A); peek(1'b0, got); chk("R4 pending select", got, 8'h31);
    wr_op(1'b0, 8'h0B); peek(1'b0, got); chk("R4 in-service select", got, 8'h02);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule